// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synchronous static RAM built from plain logic around a generic array of byte lanes. Every address, data and control input is taken on the rising clock edge. An access opens a burst when one of two start strobes is raised together with the chip select. After that, the two lowest address bits are produced inside the block, and they step forward only on cycles that raise the advance input. A level input picks the step order: either a sequential wrap within a group of four words, or an XOR pattern taken from the starting word.

The processor start strobe always opens a read. The controller start strobe, and every continuation cycle of a burst, reads or writes according to the write controls. Those controls can write single byte lanes or every lane at once. Read data passes through one register stage before it reaches the data pins. The pins float whenever output enable is low, when sleep is high, or when the pipelined read holds no valid data. Output enable, sleep and the order select act as levels without being clocked. A strobe raised without chip select ends the burst, and the pins go idle one cycle later.

Top module: `sburst_sram`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge), `dq` is high-impedance and no burst is open, so cycles without a strobe make no access.
- R2: A read taken at clock edge k places its word on `dq` after edge k+1. The word stays there until edge k+2.
- R3: `start_cpu` together with `chip_sel` loads `addr` and reads that word. `wr_en`, `global_wr` and `byte_wr` are ignored on that cycle.
- R4: `start_ctl` together with `chip_sel` loads `addr` and performs the write selected by the write controls. If no lane is selected, it performs a read.
- R5: With no strobe and `adv` low, an open burst accesses the same word again. With `adv` high, the 2-bit beat count increments by one before the access.
- R6: With `order_ilv` = 0, the low two address bits are (start + beat) mod 4. The upper address bits stay fixed, so a burst wraps inside its group of four.
- R7: With `order_ilv` = 1, the low two address bits are start XOR beat.
- R8: Lane i is `dq`/`din` bits [9i+8:9i]. It is written when `wr_en` and `byte_wr[i]` are both high. Lanes that are not selected keep their contents, and nothing is written when `wr_en` is low.
- R9: Every lane is written when `global_wr` is high, or when `wr_en` is high together with all `byte_wr` bits.
- R10: A strobe raised while `chip_sel` is low closes the burst. `dq` goes high-impedance after the next edge, and later cycles without a strobe make no access.
- R11: `dq` is high-impedance at once whenever `out_en` is low.
- R12: While `sleep` is high, strobes, advances and writes are ignored, `dq` is high-impedance, and both the array contents and the burst position are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W | Word address loaded by a start strobe |
| din | input | DATA_W | Write data, NUM_BYTES lanes of BYTE_W bits |
| dq | output | DATA_W | Pipelined read data, high-impedance when not driven |
| chip_sel | input | 1 | Selects the block on a strobe cycle; low with a strobe deselects |
| start_cpu | input | 1 | Processor start strobe, always a read |
| start_ctl | input | 1 | Controller start strobe, follows write controls |
| adv | input | 1 | Steps the burst beat count |
| wr_en | input | 1 | Write enable qualifying `byte_wr` |
| global_wr | input | 1 | Writes all lanes |
| byte_wr | input | NUM_BYTES | Per-lane write selects |
| out_en | input | 1 | Output enable, level, not clocked |
| order_ilv | input | 1 | Burst order: 0 sequential, 1 XOR; level, not clocked |
| sleep | input | 1 | Ignores accesses and floats outputs; level, not clocked |

## Verification
The bench uses the default parameters: 10 address bits and two 9-bit lanes. At that size it can write every one of the 1024 words in wrapping bursts, with each burst starting at a different offset, and then read all of them back in XOR order. Every start offset is exercised in both orders. In the sequential read bursts, holds and advances are interleaved so that the beat count wraps back to the start word. The bench computes the expected word addresses and the lane-merged data on its own, and checks them against a model array.

// File: rtl/sburst_pkg.sv
package sburst_pkg;

  // Low two address bits of a burst beat.
  // ilv = 0: sequential wrap; ilv = 1: XOR with start.
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] beat,
                                           input logic       ilv);
    logic [1:0] r;
    if (ilv) r = start ^ beat;
    else     r = start + beat;
    return r;
  endfunction

endpackage

// File: rtl/sburst_addr_gen.sv
module sburst_addr_gen #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              load,
  input  logic              stop,
  input  logic              adv,
  input  logic              order_ilv,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              active,
  output logic [1:0]        beat,
  output logic [ADDR_W-1:0] acc_addr
);

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        beat_next;

  always_comb beat_next = (active && adv) ? beat + 2'd1 : beat;

  always_comb begin
    if (load) acc_addr = ld_addr;
    else      acc_addr = {base_q[ADDR_W-1:2],
                          sburst_pkg::burst_low(base_q[1:0], beat_next, order_ilv)};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      beat   <= 2'd0;
      base_q <= '0;
    end else if (!hold) begin
      if (load) begin
        active <= 1'b1;
        beat   <= 2'd0;
        base_q <= ld_addr;
      end else if (stop) begin
        active <= 1'b0;
      end else if (active) begin
        beat <= beat_next;
      end
    end
  end

  // R5: no advance keeps the beat, advance steps it
  p_hold_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !hold && !load && !stop && !adv) |=> (beat == $past(beat)));
  p_step_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !hold && !load && !stop && adv) |=> (beat == $past(beat) + 2'd1));
  // R12: sleep freezes the burst position
  p_sleep_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(beat) && $stable(active)));

endmodule

// File: rtl/sburst_ctl.sv
module sburst_ctl #(
  parameter int NUM_BYTES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sleep,
  input  logic                 chip_sel,
  input  logic                 start_cpu,
  input  logic                 start_ctl,
  input  logic                 active,
  input  logic                 wr_en,
  input  logic                 global_wr,
  input  logic [NUM_BYTES-1:0] byte_wr,
  output logic                 load,
  output logic                 stop,
  output logic                 access,
  output logic                 is_read,
  output logic [NUM_BYTES-1:0] wr_mask
);

  logic                 strobe;
  logic [NUM_BYTES-1:0] lanes;

  always_comb begin
    strobe = start_cpu || start_ctl;
    load   = !sleep && strobe && chip_sel;
    stop   = !sleep && strobe && !chip_sel;
    access = load || (!sleep && !strobe && active);
    if (global_wr)  lanes = '1;
    else if (wr_en) lanes = byte_wr;
    else            lanes = '0;
    wr_mask = (access && !start_cpu) ? lanes : '0;
    is_read = access && (wr_mask == '0);
  end

  // R3: processor strobe never writes
  p_cpu_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && start_cpu && chip_sel) |-> (is_read && wr_mask == '0));
  // R9: global write selects every lane on an access
  p_global_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (access && !start_cpu && global_wr) |-> (&wr_mask));
  // R12: sleep blocks every access
  p_sleep_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (!access && !is_read && wr_mask == '0));

endmodule

// File: rtl/sburst_array.sv
module sburst_array #(
  parameter int ADDR_W    = 10,
  parameter int BYTE_W    = 9,
  parameter int NUM_BYTES = 2,
  localparam int DATA_W   = BYTE_W * NUM_BYTES,
  localparam int DEPTH    = 1 << ADDR_W
) (
  input  logic                 clk,
  input  logic [NUM_BYTES-1:0] we_mask,
  input  logic [ADDR_W-1:0]    waddr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    raddr,
  output logic [DATA_W-1:0]    rdata
);

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we_mask[g]) lane_mem[waddr] <= wdata[g*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk) begin
      if (rd_en) rdata[g*BYTE_W +: BYTE_W] <= lane_mem[raddr];
    end
  end

endmodule

// File: rtl/sburst_sram.sv
module sburst_sram #(
  parameter int ADDR_W    = 10,
  parameter int BYTE_W    = 9,
  parameter int NUM_BYTES = 2,
  localparam int DATA_W   = BYTE_W * NUM_BYTES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    din,
  output logic [DATA_W-1:0]    dq,
  input  logic                 chip_sel,
  input  logic                 start_cpu,
  input  logic                 start_ctl,
  input  logic                 adv,
  input  logic                 wr_en,
  input  logic                 global_wr,
  input  logic [NUM_BYTES-1:0] byte_wr,
  input  logic                 out_en,
  input  logic                 order_ilv,
  input  logic                 sleep
);

  logic                 active, load_w, stop_w, access_w, is_read_w;
  logic [1:0]           beat;
  logic [ADDR_W-1:0]    acc_addr;
  logic [NUM_BYTES-1:0] wr_mask;
  logic                 rd_v1, out_v, drive;
  logic [ADDR_W-1:0]    rd_addr_q;
  logic [DATA_W-1:0]    rdata;

  sburst_ctl #(.NUM_BYTES(NUM_BYTES)) u_ctl (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .chip_sel(chip_sel),
    .start_cpu(start_cpu), .start_ctl(start_ctl), .active(active),
    .wr_en(wr_en), .global_wr(global_wr), .byte_wr(byte_wr),
    .load(load_w), .stop(stop_w), .access(access_w),
    .is_read(is_read_w), .wr_mask(wr_mask)
  );

  sburst_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
    .clk(clk), .rst_n(rst_n), .hold(sleep), .load(load_w), .stop(stop_w),
    .adv(adv), .order_ilv(order_ilv), .ld_addr(addr),
    .active(active), .beat(beat), .acc_addr(acc_addr)
  );

  sburst_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_mem (
    .clk(clk), .we_mask(wr_mask), .waddr(acc_addr), .wdata(din),
    .rd_en(rd_v1), .raddr(rd_addr_q), .rdata(rdata)
  );

  // Read pipeline: request register, then output register.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_v1     <= 1'b0;
      out_v     <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      rd_v1     <= is_read_w;
      out_v     <= rd_v1;
      if (is_read_w) rd_addr_q <= acc_addr;
    end
  end

  assign drive = out_v && out_en && !sleep;
  assign dq    = drive ? rdata : {DATA_W{1'bz}};

  // R2: a read two edges back yields valid output now
  p_rd_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(is_read_w, 2) |-> out_v);
  // R10: a deselect two edges back leaves the output idle
  p_desel_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_w, 2) |-> !out_v);
  // R11: output enable low never drives
  p_oe_float_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> !drive);
  // R1: no access without a burst after reset
  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !start_cpu && !start_ctl) |-> !access_w);

endmodule

// File: tb/sburst_sram_test.sv
module sburst_sram_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DW = 18;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  wire  [DW-1:0] dq;
  logic chip_sel = 0, start_cpu = 0, start_ctl = 0, adv = 0;
  logic wr_en = 0, global_wr = 0, out_en = 1, order_ilv = 0, sleep = 0;
  logic [1:0] byte_wr = '0;

  int n_checks = 0;
  int n_fail   = 0;

  logic [DW-1:0] model [WORDS];
  int   m_base = 0, m_cnt = 0;
  bit   m_active = 0;
  bit   e_v0 = 0, e_v1 = 0;
  logic [DW-1:0] e_d0 = '0, e_d1 = '0;
  string e_t0 = "R1", e_t1 = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  sburst_sram uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .dq(dq),
    .chip_sel(chip_sel), .start_cpu(start_cpu), .start_ctl(start_ctl),
    .adv(adv), .wr_en(wr_en), .global_wr(global_wr), .byte_wr(byte_wr),
    .out_en(out_en), .order_ilv(order_ilv), .sleep(sleep)
  );

  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a * 2731 + 5541) % (1 << DW));
  endfunction

  task automatic check_out();
    logic [DW-1:0] expv;
    string tg;
    tg = !out_en ? "R11" : (sleep ? "R12" : e_t1);
    expv = (e_v1 && out_en && !sleep) ? e_d1 : {DW{1'bz}};
    n_checks++;
    if (dq !== expv) begin
      n_fail++;
      $display("FAIL %s dq=%h expected %h", tg, dq, expv);
    end
  endtask

  // One cycle: called at a falling edge; checks, drives, models, waits.
  task automatic step(input bit c_cpu, input bit c_ctl, input bit c_cs,
                      input bit c_adv, input bit c_we, input bit c_gw,
                      input logic [1:0] c_bw, input int c_addr,
                      input logic [DW-1:0] c_din, input bit c_ilv,
                      input bit c_oe, input bit c_slp, input string tag);
    bit acc, nv;
    int a, low;
    logic [1:0] mask;
    logic [DW-1:0] nd;
    check_out();
    start_cpu = c_cpu; start_ctl = c_ctl; chip_sel = c_cs; adv = c_adv;
    wr_en = c_we; global_wr = c_gw; byte_wr = c_bw; addr = AW'(c_addr);
    din = c_din; order_ilv = c_ilv; out_en = c_oe; sleep = c_slp;
    acc = 0; nv = 0; nd = '0; a = 0;
    if (!c_slp) begin
      if ((c_cpu || c_ctl) && c_cs) begin
        m_base = c_addr; m_cnt = 0; m_active = 1; a = c_addr; acc = 1;
      end else if (c_cpu || c_ctl) begin
        m_active = 0;
      end else if (m_active) begin
        if (c_adv) m_cnt = (m_cnt + 1) % 4;
        low = c_ilv ? ((m_base % 4) ^ m_cnt) : ((m_base % 4 + m_cnt) % 4);
        a = (m_base / 4) * 4 + low;
        acc = 1;
      end
      if (acc) begin
        if (c_cpu)      mask = 2'b00;
        else if (c_gw)  mask = 2'b11;
        else if (c_we)  mask = c_bw;
        else            mask = 2'b00;
        if (mask[0]) model[a][8:0]  = c_din[8:0];
        if (mask[1]) model[a][17:9] = c_din[17:9];
        if (mask == 2'b00) begin nv = 1; nd = model[a]; end
      end
    end
    e_v1 = e_v0; e_d1 = e_d0; e_t1 = e_t0;
    e_v0 = nv;   e_d0 = nd;   e_t0 = tag;
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    step(0,0,0,0,0,0,2'b00,0,'0,0,1,0,tag);
  endtask

  task automatic desel(input string tag);
    step(1,0,0,0,0,0,2'b00,0,'0,0,1,0,tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: quiet after reset, including advance without burst
    idle("R1"); step(0,0,0,1,0,0,2'b00,0,'0,0,1,0,"R1"); idle("R1"); idle("R1");

    // Fill: sequential write bursts, every start offset; R4 then R9 beats
    for (int b = 0; b < WORDS/4; b++) begin
      for (int j = 0; j < 4; j++) begin
        int s = b % 4;
        int wa = b*4 + (s + j) % 4;
        if (j == 0) step(0,1,1,0,0,1,2'b00,wa,pat(wa),0,1,0,"R4");
        else        step(0,0,0,1,1,0,2'b11,0,pat(wa),0,1,0,"R9");
      end
    end
    desel("R10"); idle("R10");

    // XOR-order read of all words; processor strobe carries write controls (R3)
    for (int b = 0; b < WORDS/4; b++) begin
      for (int j = 0; j < 4; j++) begin
        int s = (b * 3) % 4;
        if (j == 0) step(1,0,1,0,1,1,2'b11,b*4+s,'1,1,1,0,"R3");
        else        step(0,0,0,1,0,0,2'b00,0,'0,1,1,0,"R7");
      end
    end
    desel("R10"); idle("R2"); idle("R2");

    // Sequential reads with holds, wrapping past the start (R5, R6)
    for (int b = 0; b < 16; b++) begin
      step(1,0,1,0,0,0,2'b00,b*37 % WORDS,'0,0,1,0,"R6");
      step(0,0,0,0,0,0,2'b00,0,'0,0,1,0,"R5");
      for (int k = 0; k < 4; k++) step(0,0,0,1,0,0,2'b00,0,'0,0,1,0,"R6");
      step(0,0,0,0,0,0,2'b00,0,'0,0,1,0,"R5");
    end
    desel("R10"); idle("R10"); idle("R10");

    // Lane writes (R8)
    step(0,1,1,0,1,0,2'b01,100,18'h2A5A5,0,1,0,"R8");
    step(0,1,1,0,0,0,2'b11,100,18'h3FFFF,0,1,0,"R8");
    step(0,1,1,0,1,0,2'b10,101,18'h15A5A,0,1,0,"R8");
    step(1,0,1,0,0,0,2'b00,101,'0,0,1,0,"R8");
    step(0,1,1,0,1,0,2'b11,102,18'h0F0F0,0,1,0,"R9");
    step(0,1,1,0,0,0,2'b00,102,'0,0,1,0,"R4");
    desel("R10"); idle("R10"); idle("R10");

    // Deselect right after a read (R10); controller strobe deselect too
    step(1,0,1,0,0,0,2'b00,200,'0,0,1,0,"R2");
    desel("R10");
    step(0,0,0,1,0,0,2'b00,0,'0,0,1,0,"R10");
    step(0,1,0,0,0,1,2'b00,0,'0,0,1,0,"R10");
    idle("R10"); idle("R10");

    // Output enable low mid-burst (R11)
    step(1,0,1,0,0,0,2'b00,300,'0,0,1,0,"R2");
    step(0,0,0,1,0,0,2'b00,0,'0,0,0,0,"R11");
    step(0,0,0,1,0,0,2'b00,0,'0,0,0,0,"R11");
    step(0,0,0,1,0,0,2'b00,0,'0,0,1,0,"R11");
    desel("R10"); idle("R10"); idle("R10");

    // Sleep (R12): writes, strobes and advances ignored, position kept
    step(1,0,1,0,0,0,2'b00,400,'0,0,1,0,"R12");
    step(0,0,0,1,0,0,2'b00,0,'0,0,1,0,"R12");
    step(0,1,1,1,1,1,2'b11,400,'0,0,1,1,"R12");
    step(0,0,0,1,1,1,2'b11,0,'0,0,1,1,"R12");
    step(1,0,0,1,0,0,2'b00,0,'0,0,1,1,"R12");
    step(0,0,0,1,0,0,2'b00,0,'0,0,1,0,"R12");
    step(0,0,0,1,0,0,2'b00,0,'0,0,1,0,"R12");
    step(1,0,1,0,0,0,2'b00,400,'0,0,1,0,"R12");
    desel("R10"); idle("R12"); idle("R12"); idle("R12");

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule